// File: doc/BRIEF.md
# Tuning PLL Reference Divider, Phase Comparator and Lock Indicator

This block is the digital comparison core of a frequency-synthesis tuning loop. It divides the crystal reference clock down to a comparison rate and measures the timing of each divided reference edge against a one-cycle feedback pulse from the VCO divider chain. From that comparison it issues up and down commands to an external charge pump. It also carries the pump current level and the pump enable to the analog side, and it raises a lock flag once the loop has settled.

The division ratio is 512, 640 or 1024. A 3-bit mode input selects it, and in the programmable mode a 2-bit ratio code selects it instead. With a 4 MHz crystal these ratios give comparison rates of 7.8125 kHz, 6.25 kHz and 3.90625 kHz. A new ratio is applied only at a terminal count, so the current comparison period always runs to completion. The whole block runs on the reference clock. The feedback pulse is expected to be synchronous to that clock, one cycle wide.

Top module: `tune_ref_path`

## Requirements
- R1: The ratio follows `mode_sel`: 0 gives 1024, 1 gives 512, 2 gives 640, 3 gives 512, and the unused values 5 to 7 give 512. `ratio_code` has no effect in these modes.
- R2: With `mode_sel` = 4, `ratio_code` sets the ratio. Bit 0 = 0 gives 640 whatever bit 1 is. Code 2'b01 gives 1024 and code 2'b11 gives 512.
- R3: A change of `mode_sel` or `ratio_code` takes effect at the next reference terminal count. The comparison period already in progress keeps the old ratio.
- R4: `up` rises one cycle after a reference terminal count, and `dn` rises one cycle after a feedback pulse. Each stays high until the other event arrives.
- R5: When the second event of a comparison arrives, both `up` and `dn` are low in the next cycle. A terminal count coinciding with a feedback pulse raises neither. `up` and `dn` are never high together.
- R6: `lock` goes high after LOCK_CNT (default 4) consecutive comparisons whose pulse width, meaning the cycles `up` or `dn` is high, is at most LOCK_TOL (default 4).
- R7: `lock` goes low in the cycle after the pulse width first reaches LOCK_TOL+1 cycles. This covers a missing feedback pulse. A width of exactly LOCK_TOL keeps it high.
- R8: `pump_hi` follows `cp_hi` and `pump_en` follows the inverse of `cp_off`, each one cycle later. While the pump is disabled, `up` and `dn` stay low.
- R9: During synchronous reset, `up`, `dn`, `lock`, `pump_en` and `pump_hi` are low. After reset the first `up` rises exactly one ratio of cycles after the first non-reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Step mode, 0 to 4 |
| ratio_code | input | 2 | Ratio code used in mode 4 |
| fb_pulse | input | 1 | One-cycle divided VCO pulse |
| cp_hi | input | 1 | Request for the high pump current |
| cp_off | input | 1 | Disable the charge pump |
| up | output | 1 | Pump-up command |
| dn | output | 1 | Pump-down command |
| pump_hi | output | 1 | High current level selected |
| pump_en | output | 1 | Pump enabled; low means high impedance |
| lock | output | 1 | Loop locked |

## Verification
Several properties are watched on every cycle: the exclusion between `up` and `dn`, their masking while the pump is off, and the one-cycle following of the pump controls. The checker also confirms that an `up` with no feedback holds, and that `lock` is never high once a pulse has outlived the tolerance. The exact ratio for each mode and code, and the deferral of a ratio change to the next terminal count, can only be shown by the bench measuring edge spacing. The same is true of the boundary between a pulse width of LOCK_TOL and LOCK_TOL+1, and of the count of good comparisons needed to declare lock.

// File: rtl/tune_ref_pkg.sv
package tune_ref_pkg;

  typedef enum logic [1:0] {
    RSEL_LONG  = 2'd0,
    RSEL_SHORT = 2'd1,
    RSEL_MID   = 2'd2
  } ratio_sel_e;

  localparam logic [2:0] MODE_PROG = 3'd4;

  function automatic ratio_sel_e decode_ratio(input logic [2:0] mode,
                                              input logic [1:0] code);
    ratio_sel_e sel;
    case (mode)
      3'd0:    sel = RSEL_LONG;
      3'd1:    sel = RSEL_SHORT;
      3'd2:    sel = RSEL_MID;
      3'd3:    sel = RSEL_SHORT;
      MODE_PROG: begin
        if (!code[0])     sel = RSEL_MID;
        else if (code[1]) sel = RSEL_SHORT;
        else              sel = RSEL_LONG;
      end
      default: sel = RSEL_SHORT;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/tune_ref_div.sv
module tune_ref_div
  import tune_ref_pkg::*;
#(
  parameter int RATIO_LONG  = 1024,
  parameter int RATIO_SHORT = 512,
  parameter int RATIO_MID   = 640,
  parameter int CNT_W       = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_sel,
  input  logic [1:0] ratio_code,
  output logic       ref_tick
);

  localparam logic [CNT_W-1:0] TERM_LONG  = CNT_W'(RATIO_LONG - 1);
  localparam logic [CNT_W-1:0] TERM_SHORT = CNT_W'(RATIO_SHORT - 1);
  localparam logic [CNT_W-1:0] TERM_MID   = CNT_W'(RATIO_MID - 1);

  ratio_sel_e       sel_q;
  ratio_sel_e       sel_next;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign sel_next = decode_ratio(mode_sel, ratio_code);

  always_comb begin
    case (sel_q)
      RSEL_LONG:  term = TERM_LONG;
      RSEL_MID:   term = TERM_MID;
      default:    term = TERM_SHORT;
    endcase
  end

  assign ref_tick = (cnt_q == term);

  // The ratio register is reloaded only at the terminal count.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= sel_next;
    end else if (ref_tick) begin
      cnt_q <= '0;
      sel_q <= sel_next;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tune_pfd.sv
module tune_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic fb_pulse,
  input  logic pump_off,
  output logic up_q,
  output logic dn_q,
  output logic up_o,
  output logic dn_o,
  output logic cmp_done
);

  logic up_set;
  logic dn_set;
  logic up_next;
  logic dn_next;

  assign up_set   = up_q | ref_tick;
  assign dn_set   = dn_q | fb_pulse;
  assign cmp_done = up_set & dn_set;
  assign up_next  = up_set & ~cmp_done;
  assign dn_next  = dn_set & ~cmp_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_q <= up_next;
      dn_q <= dn_next;
      up_o <= up_next & ~pump_off;
      dn_o <= dn_next & ~pump_off;
    end
  end

endmodule

// File: rtl/tune_lock_det.sv
module tune_lock_det #(
  parameter int LOCK_TOL = 4,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic up_q,
  input  logic dn_q,
  input  logic cmp_done,
  output logic lock
);

  localparam int WW = $clog2(LOCK_TOL + 2);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [WW-1:0] TOL_V  = WW'(LOCK_TOL);
  localparam logic [GW-1:0] CNT_V  = GW'(LOCK_CNT);
  localparam logic [GW-1:0] LAST_V = GW'(LOCK_CNT - 1);

  logic [WW-1:0] wcnt_q;
  logic [GW-1:0] good_q;
  logic          active;
  logic          overrun;

  assign active  = up_q | dn_q;
  assign overrun = active && (wcnt_q >= TOL_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q <= '0;
      good_q <= '0;
      lock   <= 1'b0;
    end else begin
      if (cmp_done || !active)  wcnt_q <= '0;
      else if (wcnt_q != TOL_V) wcnt_q <= wcnt_q + 1'b1;

      if (overrun) begin
        good_q <= '0;
        lock   <= 1'b0;
      end else if (cmp_done && good_q != CNT_V) begin
        good_q <= good_q + 1'b1;
        if (good_q == LAST_V) lock <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tune_ref_path.sv
module tune_ref_path #(
  parameter int RATIO_LONG  = 1024,
  parameter int RATIO_SHORT = 512,
  parameter int RATIO_MID   = 640,
  parameter int LOCK_TOL    = 4,
  parameter int LOCK_CNT    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_sel,
  input  logic [1:0] ratio_code,
  input  logic       fb_pulse,
  input  logic       cp_hi,
  input  logic       cp_off,
  output logic       up,
  output logic       dn,
  output logic       pump_hi,
  output logic       pump_en,
  output logic       lock
);

  localparam int RMAX_A = (RATIO_LONG > RATIO_SHORT) ? RATIO_LONG : RATIO_SHORT;
  localparam int RMAX   = (RMAX_A > RATIO_MID) ? RMAX_A : RATIO_MID;
  localparam int CNT_W  = $clog2(RMAX);

  logic ref_tick;
  logic up_q;
  logic dn_q;
  logic cmp_done;

  tune_ref_div #(
    .RATIO_LONG (RATIO_LONG),
    .RATIO_SHORT(RATIO_SHORT),
    .RATIO_MID  (RATIO_MID),
    .CNT_W      (CNT_W)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .ratio_code(ratio_code),
    .ref_tick  (ref_tick)
  );

  tune_pfd u_pfd (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .fb_pulse(fb_pulse),
    .pump_off(cp_off),
    .up_q    (up_q),
    .dn_q    (dn_q),
    .up_o    (up),
    .dn_o    (dn),
    .cmp_done(cmp_done)
  );

  tune_lock_det #(
    .LOCK_TOL(LOCK_TOL),
    .LOCK_CNT(LOCK_CNT)
  ) u_lock (
    .clk     (clk),
    .rst     (rst),
    .up_q    (up_q),
    .dn_q    (dn_q),
    .cmp_done(cmp_done),
    .lock    (lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_hi <= 1'b0;
      pump_en <= 1'b0;
    end else begin
      pump_hi <= cp_hi;
      pump_en <= ~cp_off;
    end
  end

endmodule

// File: rtl/tune_ref_path_chk.sv
module tune_ref_path_chk #(
  parameter int LOCK_TOL = 4
) (
  input logic clk,
  input logic rst,
  input logic fb_pulse,
  input logic cp_hi,
  input logic cp_off,
  input logic up,
  input logic dn,
  input logic pump_hi,
  input logic pump_en,
  input logic lock
);

  localparam int RW = $clog2(LOCK_TOL + 3);
  localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_TOL + 1);

  logic [RW-1:0] run_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (!(up || dn))          run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  AST_UPDN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(up && dn)); // R5

  AST_PUMP_MASK: assert property (@(posedge clk) disable iff (rst)
    !pump_en |-> (!up && !dn)); // R8

  AST_PUMP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (pump_en == !$past(cp_off)) && (pump_hi == $past(cp_hi))); // R8

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up && !fb_pulse && !cp_off) |=> up); // R4

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    (run_q == RUN_MAX) |-> !lock); // R7

  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (!up && !dn)); // R6

endmodule

bind tune_ref_path tune_ref_path_chk #(.LOCK_TOL(LOCK_TOL)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fb_pulse(fb_pulse),
  .cp_hi   (cp_hi),
  .cp_off  (cp_off),
  .up      (up),
  .dn      (dn),
  .pump_hi (pump_hi),
  .pump_en (pump_en),
  .lock    (lock)
);

// File: tb/tune_ref_path_bench.sv
module tune_ref_path_bench;

  localparam int NVEC = 11;
  // {mode[2:0], code[1:0], expected ratio[10:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 11'd1024},
    {3'd1, 2'b00, 11'd512},
    {3'd2, 2'b00, 11'd640},
    {3'd3, 2'b00, 11'd512},
    {3'd4, 2'b01, 11'd1024},
    {3'd4, 2'b11, 11'd512},
    {3'd4, 2'b00, 11'd640},
    {3'd4, 2'b10, 11'd640},
    {3'd0, 2'b11, 11'd1024},
    {3'd5, 2'b01, 11'd1024 - 11'd512},
    {3'd7, 2'b11, 11'd512}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'd1;
  logic [1:0] ratio_code = 2'b00;
  logic       dir_fb = 1'b0;
  logic       resp_fb = 1'b0;
  logic       fb_pulse;
  logic       cp_hi = 1'b0;
  logic       cp_off = 1'b0;
  logic       up, dn, pump_hi, pump_en, lock;

  logic       resp_en = 1'b0;
  int         resp_dly = 0;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  assign fb_pulse = dir_fb | resp_fb;

  tune_ref_path u_tune_ref_path (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ratio_code(ratio_code),
    .fb_pulse(fb_pulse), .cp_hi(cp_hi), .cp_off(cp_off),
    .up(up), .dn(dn), .pump_hi(pump_hi), .pump_en(pump_en), .lock(lock)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_rise(output int t);
    logic p;
    p = up;
    forever begin
      @(negedge clk);
      if (up && !p) break;
      p = up;
    end
    t = cyc;
  endtask

  // Feedback model: answers each up pulse after resp_dly cycles
  initial begin
    forever begin
      @(negedge clk);
      if (resp_en && up) begin
        repeat (resp_dly) @(negedge clk);
        resp_fb = 1'b1;
        @(negedge clk);
        resp_fb = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, hits;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 up in reset", up, 0);
    check("R9 dn in reset", dn, 0);
    check("R9 lock in reset", lock, 0);
    check("R9 pump_en in reset", pump_en, 0);
    rst = 1'b0;
    t0 = cyc;
    wait_rise(t1);
    check("R9 first up after reset", t1 - t0, 512);
    repeat (20) @(negedge clk);
    check("R4 up holds without feedback", up, 1);
    check("R4 dn stays low", dn, 0);
    dir_fb = 1'b1;
    @(negedge clk);
    dir_fb = 1'b0;
    check("R5 up cleared by feedback", up, 0);
    check("R5 dn not raised", dn, 0);

    // Table walk: R1 and R2 ratios
    resp_en = 1'b1;
    resp_dly = 0;
    for (int i = 0; i < NVEC; i++) begin
      mode_sel   = VEC[i][15:13];
      ratio_code = VEC[i][12:11];
      wait_rise(t1);
      wait_rise(t1);
      wait_rise(t2);
      check((VEC[i][15:13] == 3'd4) ? "R2 ratio" : "R1 ratio", t2 - t1, int'(VEC[i][10:0]));
    end

    // R3: ratio change deferred to the next terminal count
    mode_sel = 3'd1;
    wait_rise(t1);
    wait_rise(t1);
    mode_sel = 3'd0;
    wait_rise(t2);
    wait_rise(t3);
    check("R3 period in progress keeps old ratio", t2 - t1, 512);
    check("R3 new ratio after terminal count", t3 - t2, 1024);
    mode_sel = 3'd1;
    wait_rise(t1);

    // R4: dn rises on feedback while up is low
    resp_en = 1'b0;
    wait_rise(t1);
    dir_fb = 1'b1;
    @(negedge clk);
    dir_fb = 1'b0;
    repeat (5) @(negedge clk);
    dir_fb = 1'b1;
    @(negedge clk);
    dir_fb = 1'b0;
    check("R4 dn raised by feedback", dn, 1);
    check("R4 up low while dn pending", up, 0);

    // R5: coincident terminal count and feedback raise neither output
    resp_en = 1'b1;
    wait_rise(t1);
    wait_rise(t1);
    resp_en = 1'b0;
    @(negedge clk);
    repeat (510) @(negedge clk);
    dir_fb = 1'b1;
    @(negedge clk);
    dir_fb = 1'b0;
    check("R5 coincident edges up", up, 0);
    check("R5 coincident edges dn", dn, 0);
    repeat (3) @(negedge clk);
    check("R5 coincident edges still quiet", up | dn, 0);

    // R7: missing feedback drops lock
    wait_rise(t1);
    repeat (10) @(negedge clk);
    check("R7 lock low on lost feedback", lock, 0);
    dir_fb = 1'b1;
    @(negedge clk);
    dir_fb = 1'b0;

    // R6: lock after LOCK_CNT good comparisons
    resp_en = 1'b1;
    resp_dly = 0;
    repeat (4) wait_rise(t1);
    check("R6 lock low after three good comparisons", lock, 0);
    repeat (2) @(negedge clk);
    check("R6 lock high after four good comparisons", lock, 1);

    // R7: width LOCK_TOL keeps lock, LOCK_TOL+1 drops it
    resp_dly = 3;
    repeat (3) wait_rise(t1);
    repeat (6) @(negedge clk);
    check("R7 width at tolerance keeps lock", lock, 1);
    resp_dly = 4;
    wait_rise(t1);
    repeat (4) @(negedge clk);
    check("R7 lock held before overrun", lock, 1);
    @(negedge clk);
    check("R7 lock dropped after overrun", lock, 0);
    resp_dly = 0;

    // R8: pump controls
    cp_hi = 1'b1;
    @(negedge clk);
    check("R8 pump_hi follows", pump_hi, 1);
    cp_off = 1'b1;
    @(negedge clk);
    check("R8 pump disabled", pump_en, 0);
    hits = 0;
    repeat (1100) begin
      @(negedge clk);
      if (up || dn) hits++;
    end
    check("R8 commands masked while disabled", hits, 0);
    cp_off = 1'b0;
    cp_hi  = 1'b0;
    @(negedge clk);
    check("R8 pump re-enabled", pump_en, 1);
    check("R8 pump_hi low", pump_hi, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule